// File: doc/BRIEF.md
# Multi-Sensor Thermal Trip Monitor

This block watches the most recent temperature sample from each of four on-chip sensors and compares it against thresholds programmed for that sensor. Sensor lane 0 is the CPU, lane 1 the memory, lane 2 the GPU and lane 3 the PLL. All values are signed millidegrees Celsius. A sample is taken into account only in the clock cycle in which its valid strobe is high.

There are three responses, each more severe than the one before. A hot flag per sensor asks for hardware clock throttling. The hot flag has hysteresis: it sets when the temperature rises above the hot threshold and clears only when it falls below that threshold minus a shared hysteresis amount. A critical breach is handled in one of two ways. If the sensor has its own dedicated shutdown threshold enabled, that threshold drives the external thermal-trip line, and a critical breach only sets a per-sensor status bit that raises a software interrupt. If no dedicated shutdown threshold is enabled, the critical threshold itself drives the thermal-trip line. The thermal-trip output goes to the external power-management device. Once set, it stays set until reset.

Top module: `thermal_trip_monitor`

## Requirements
- R1: After reset, every hot flag, every critical status bit, the critical interrupt and the thermal-trip output are 0.
- R2: A valid sample strictly greater than an enabled hot threshold sets that sensor's hot flag on the next clock edge. A sample equal to the threshold does not set it.
- R3: A set hot flag clears only when a valid sample is strictly below the hot threshold minus the hysteresis. A sample between that value and the hot threshold, including one exactly equal to the lower value, leaves the flag unchanged.
- R4: A sample whose valid strobe is low changes no flag, status bit or trip output.
- R5: When a sensor's hot enable is low, its hot flag is cleared on the next edge and stays 0 for any sample.
- R6: With the dedicated shutdown enable of a sensor at 1, a valid sample strictly above that sensor's shutdown threshold sets the thermal-trip output on the next edge. A sample equal to the threshold does not.
- R7: With the dedicated shutdown enable of a sensor at 0 and its critical enable at 1, a valid sample strictly above the critical threshold sets the thermal-trip output, and the critical status bit stays 0.
- R8: With the dedicated shutdown enable at 1 and the critical enable at 1, a valid sample strictly above the critical threshold sets that sensor's critical status bit and the critical interrupt, and does not set the thermal-trip output.
- R9: A critical status bit stays set until its clear input is pulsed. If a set and a clear arrive in the same cycle, the set wins. The critical interrupt is high exactly while any status bit is set.
- R10: The thermal-trip output, once set, stays 1 regardless of later samples, and only reset clears it.
- R11: Each sensor lane i occupies bits [i*TEMP_W +: TEMP_W] of the packed buses and bit i of the per-sensor vectors. Lanes act independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_vld | input | NUM_SENSORS | Per-sensor sample strobe |
| sample_mdeg | input | NUM_SENSORS*TEMP_W | Packed signed temperature samples |
| hot_limit | input | NUM_SENSORS*TEMP_W | Packed hot thresholds |
| hot_enable | input | NUM_SENSORS | Hot comparison enables |
| crit_limit | input | NUM_SENSORS*TEMP_W | Packed critical thresholds |
| crit_enable | input | NUM_SENSORS | Critical comparison enables |
| sdn_limit | input | NUM_SENSORS*TEMP_W | Packed dedicated shutdown thresholds |
| sdn_enable | input | NUM_SENSORS | Dedicated shutdown threshold present |
| hyst_mdeg | input | HYST_W | Unsigned hysteresis for hot release |
| crit_ack | input | NUM_SENSORS | Per-sensor critical status clear pulses |
| hot_flag | output | NUM_SENSORS | Throttle requests |
| crit_status | output | NUM_SENSORS | Sticky critical status bits |
| crit_irq | output | 1 | OR of critical status bits |
| therm_trip | output | 1 | Latched request to the power-management device |

## Verification
The hardest case to reach is a hot flag sitting inside the hysteresis band. It has to be entered from above with the flag already set, then probed at the exact release boundary, with samples whose strobe is low mixed in. A vector table walks one lane through rising, banded, boundary and invalid samples in a fixed order for this reason. The two critical routes need the thermal-trip latch empty, so the bench applies reset between the fallback test and the dedicated-threshold test. Clear and set in the same cycle are driven together on purpose.

// File: rtl/ttm_pkg.sv
package ttm_pkg;
   typedef enum logic [1:0] {
      SENS_CPU = 2'd0,
      SENS_MEM = 2'd1,
      SENS_GPU = 2'd2,
      SENS_PLL = 2'd3
   } sensor_id_e;

   localparam int unsigned DEF_SENSORS = 4;
   localparam int unsigned DEF_TEMP_W  = 20;
   localparam int unsigned DEF_HYST_W  = 12;

   typedef struct packed {
      logic crit_evt;
      logic trip_evt;
   } zone_evt_t;
endpackage

// File: rtl/ttm_zone.sv
module ttm_zone #(
   parameter int unsigned TEMP_W = 20,
   parameter int unsigned HYST_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld,
   input  logic [TEMP_W-1:0] temp,
   input  logic [TEMP_W-1:0] hot_th,
   input  logic              hot_en,
   input  logic [TEMP_W-1:0] crit_th,
   input  logic              crit_en,
   input  logic [TEMP_W-1:0] sdn_th,
   input  logic              sdn_en,
   input  logic [HYST_W-1:0] hyst,
   output logic              hot,
   output ttm_pkg::zone_evt_t evt
);
   localparam int unsigned XW = TEMP_W + 1;

   if (HYST_W >= TEMP_W) begin : g_bad_hyst
      $error("ttm_zone: HYST_W must be narrower than TEMP_W");
   end

   logic signed [XW-1:0] t_x, hot_x, crit_x, sdn_x, rel_x;
   logic above_hot, below_rel, above_crit, above_sdn;

   always_comb begin
      t_x    = $signed({temp[TEMP_W-1], temp});
      hot_x  = $signed({hot_th[TEMP_W-1], hot_th});
      crit_x = $signed({crit_th[TEMP_W-1], crit_th});
      sdn_x  = $signed({sdn_th[TEMP_W-1], sdn_th});
      rel_x  = hot_x - $signed({{(XW-HYST_W){1'b0}}, hyst});
      above_hot  = t_x > hot_x;
      below_rel  = t_x < rel_x;
      above_crit = t_x > crit_x;
      above_sdn  = t_x > sdn_x;
   end

   // Hot flag with hysteresis: set above threshold, release below threshold-hyst
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             hot <= 1'b0;
      else if (!hot_en)       hot <= 1'b0;
      else if (vld) begin
         if (above_hot)       hot <= 1'b1;
         else if (below_rel)  hot <= 1'b0;
      end
   end

   // Routing of critical breach: to software when a dedicated limit exists,
   // otherwise straight to the trip line
   logic crit_hit;
   always_comb begin
      crit_hit     = vld && crit_en && above_crit;
      evt.crit_evt = crit_hit && sdn_en;
      evt.trip_evt = sdn_en ? (vld && above_sdn) : crit_hit;
   end

   assert_hot_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && hot_en && above_hot) |=> hot);
   assert_hot_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && hot_en && !above_hot && below_rel) |=> !hot);
   assert_hot_band_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hot_en && $past(hot_en) && !(vld && (above_hot || below_rel))) |=> $stable(hot));
   assert_hot_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!hot_en) |=> !hot);
endmodule

// File: rtl/ttm_crit_status.sv
module ttm_crit_status #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_evt,
   input  logic [N-1:0] clr,
   output logic [N-1:0] status,
   output logic         irq
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          status[i] <= 1'b0;
         else if (set_evt[i]) status[i] <= 1'b1;
         else if (clr[i])     status[i] <= 1'b0;
      end

      assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
         set_evt[i] |=> status[i]);
      assert_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (status[i] && !clr[i]) |=> status[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |(set_evt | (status & ~clr));
   end

   assert_irq_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (status != '0));
endmodule

// File: rtl/ttm_trip_latch.sv
module ttm_trip_latch #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] trip_evt,
   output logic         trip
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         trip <= 1'b0;
      else if (|trip_evt) trip <= 1'b1;
   end

   assert_trip_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      trip |=> trip);
   assert_trip_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|trip_evt) |=> trip);
endmodule

// File: rtl/thermal_trip_monitor.sv
module thermal_trip_monitor #(
   parameter int unsigned NUM_SENSORS = ttm_pkg::DEF_SENSORS,
   parameter int unsigned TEMP_W      = ttm_pkg::DEF_TEMP_W,
   parameter int unsigned HYST_W      = ttm_pkg::DEF_HYST_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_SENSORS-1:0]        sample_vld,
   input  logic [NUM_SENSORS*TEMP_W-1:0] sample_mdeg,
   input  logic [NUM_SENSORS*TEMP_W-1:0] hot_limit,
   input  logic [NUM_SENSORS-1:0]        hot_enable,
   input  logic [NUM_SENSORS*TEMP_W-1:0] crit_limit,
   input  logic [NUM_SENSORS-1:0]        crit_enable,
   input  logic [NUM_SENSORS*TEMP_W-1:0] sdn_limit,
   input  logic [NUM_SENSORS-1:0]        sdn_enable,
   input  logic [HYST_W-1:0]             hyst_mdeg,
   input  logic [NUM_SENSORS-1:0]        crit_ack,
   output logic [NUM_SENSORS-1:0]        hot_flag,
   output logic [NUM_SENSORS-1:0]        crit_status,
   output logic                          crit_irq,
   output logic                          therm_trip
);
   if (NUM_SENSORS < 1 || NUM_SENSORS > 64) begin : g_bad_n
      $error("thermal_trip_monitor: NUM_SENSORS out of range");
   end
   if (TEMP_W < 18) begin : g_bad_w
      $error("thermal_trip_monitor: TEMP_W too narrow for millidegree limits");
   end

   ttm_pkg::zone_evt_t [NUM_SENSORS-1:0] zevt;
   logic [NUM_SENSORS-1:0] crit_set, trip_set;

   // R11: lane i of every packed bus belongs to sensor i
   for (genvar i = 0; i < NUM_SENSORS; i++) begin : g_zone
      ttm_zone #(.TEMP_W(TEMP_W), .HYST_W(HYST_W)) u_zone (
         .clk     (clk),
         .rst_n   (rst_n),
         .vld     (sample_vld[i]),
         .temp    (sample_mdeg[i*TEMP_W +: TEMP_W]),
         .hot_th  (hot_limit[i*TEMP_W +: TEMP_W]),
         .hot_en  (hot_enable[i]),
         .crit_th (crit_limit[i*TEMP_W +: TEMP_W]),
         .crit_en (crit_enable[i]),
         .sdn_th  (sdn_limit[i*TEMP_W +: TEMP_W]),
         .sdn_en  (sdn_enable[i]),
         .hyst    (hyst_mdeg),
         .hot     (hot_flag[i]),
         .evt     (zevt[i])
      );
      assign crit_set[i] = zevt[i].crit_evt;
      assign trip_set[i] = zevt[i].trip_evt;

      assert_no_idle_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (!sample_vld[i]) |-> (!crit_set[i] && !trip_set[i]));
      assert_fallback_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (!sdn_enable[i]) |-> !crit_set[i]);
   end

   ttm_crit_status #(.N(NUM_SENSORS)) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (crit_set),
      .clr     (crit_ack),
      .status  (crit_status),
      .irq     (crit_irq)
   );

   ttm_trip_latch #(.N(NUM_SENSORS)) u_trip (
      .clk      (clk),
      .rst_n    (rst_n),
      .trip_evt (trip_set),
      .trip     (therm_trip)
   );
endmodule

// File: tb/tb_thermal_trip_monitor.sv
module tb_thermal_trip_monitor;
   localparam int N = 4;
   localparam int W = 20;
   localparam int H = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0]   vld = '0, hen = '0, cen = '0, sen = '0, ack = '0;
   logic [N*W-1:0] smp = '0, hlim = '0, clim = '0, slim = '0;
   logic [H-1:0]   hyst = '0;
   logic [N-1:0]   hot, cst;
   logic           irq, trip;
   int checks = 0, errors = 0;

   always #10 clk = ~clk;

   thermal_trip_monitor #(.NUM_SENSORS(N), .TEMP_W(W), .HYST_W(H)) dut (
      .clk(clk), .rst_n(rst_n), .sample_vld(vld), .sample_mdeg(smp),
      .hot_limit(hlim), .hot_enable(hen), .crit_limit(clim), .crit_enable(cen),
      .sdn_limit(slim), .sdn_enable(sen), .hyst_mdeg(hyst), .crit_ack(ack),
      .hot_flag(hot), .crit_status(cst), .crit_irq(irq), .therm_trip(trip));

   // Hysteresis walk on lane 0: hot 100000, hyst 1000
   localparam int NV = 10;
   localparam int VT_TEMP [NV] = '{90000, 100000, 100001, 99500, 99000,
                                   98999, 150000, 100500, 50000, 98000};
   localparam int VT_VLD  [NV] = '{1, 1, 1, 1, 1, 1, 0, 1, 0, 1};
   localparam int VT_HOT  [NV] = '{0, 0, 1, 1, 1, 0, 0, 1, 1, 0};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic put(input int lane, input int t);
      smp[lane*W +: W] = t[W-1:0];
   endtask

   task automatic configure();
      for (int i = 0; i < N; i++) begin
         hlim[i*W +: W] = 20'd100000;
         clim[i*W +: W] = 20'd105000;
      end
      slim[0*W +: W] = 20'd102500;
      slim[2*W +: W] = 20'd103000;
      sen  = 4'b0101;
      cen  = 4'b1111;
      hen  = 4'b1111;
      hyst = 12'd1000;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      vld = '0; ack = '0;
      step();
      rst_n = 1'b1;
      step();
   endtask

   initial begin
      configure();
      do_reset();
      // R1
      chk("R1 hot", {28'd0, hot}, 32'd0);
      chk("R1 status", {28'd0, cst}, 32'd0);
      chk("R1 irq", {31'd0, irq}, 32'd0);
      chk("R1 trip", {31'd0, trip}, 32'd0);

      // R2 R3 R4 R11 vector walk on lane 0
      for (int k = 0; k < NV; k++) begin
         put(0, VT_TEMP[k]);
         vld = VT_VLD[k] ? 4'b0001 : 4'b0000;
         step();
         chk("R2/R3/R4 hot[0] vector", {31'd0, hot[0]}, VT_HOT[k]);
         chk("R11 other lanes idle", {29'd0, hot[3:1]}, 32'd0);
      end
      vld = '0;
      chk("R4 no trip from invalid sample", {31'd0, trip}, 32'd0);

      // R5
      put(0, 101000); vld = 4'b0001; step();
      chk("R5 hot set before disable", {31'd0, hot[0]}, 32'd1);
      vld = '0; hen[0] = 1'b0; step();
      chk("R5 disable clears hot", {31'd0, hot[0]}, 32'd0);
      vld = 4'b0001; step();
      chk("R5 disabled stays low", {31'd0, hot[0]}, 32'd0);
      vld = '0; hen[0] = 1'b1; put(0, 90000); vld = 4'b0001; step(); vld = '0;

      // R8 lane 2: dedicated limit 103000, critical lowered to 102000
      clim[2*W +: W] = 20'd102000;
      put(2, 102500); vld = 4'b0100; step(); vld = '0;
      chk("R8 crit status lane 2", {28'd0, cst}, 32'h4);
      chk("R8 irq", {31'd0, irq}, 32'd1);
      chk("R8 no trip", {31'd0, trip}, 32'd0);
      chk("R11 hot lane 2 only", {28'd0, hot}, 32'h4);
      step(); step();
      chk("R9 status held", {28'd0, cst}, 32'h4);
      ack = 4'b0100; step(); ack = '0;
      chk("R9 clear", {28'd0, cst}, 32'd0);
      chk("R9 irq drops", {31'd0, irq}, 32'd0);
      vld = 4'b0100; ack = 4'b0100; step(); vld = '0; ack = '0;
      chk("R9 set wins over clear", {28'd0, cst}, 32'h4);
      ack = 4'b0100; step(); ack = '0;
      put(2, 90000); vld = 4'b0100; step(); vld = '0;

      // R7 lane 1 fallback (no dedicated limit), critical 105000
      put(1, 105000); vld = 4'b0010; step(); vld = '0;
      chk("R7 equal critical no trip", {31'd0, trip}, 32'd0);
      put(1, 105001); vld = 4'b0010; step(); vld = '0;
      chk("R7 fallback trip", {31'd0, trip}, 32'd1);
      chk("R7 no status in fallback", {28'd0, cst}, 32'd0);

      // R10
      put(1, 20000); vld = 4'b1111; step(); vld = '0; step();
      chk("R10 trip sticky", {31'd0, trip}, 32'd1);
      do_reset();
      chk("R10 reset clears trip", {31'd0, trip}, 32'd0);

      // R6 lane 0 dedicated limit 102500
      configure();
      put(0, 102500); vld = 4'b0001; step(); vld = '0;
      chk("R6 equal limit no trip", {31'd0, trip}, 32'd0);
      put(0, 102501); vld = 4'b0001; step(); vld = '0;
      chk("R6 dedicated trip", {31'd0, trip}, 32'd1);
      chk("R6 below critical no status", {28'd0, cst}, 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule